// File: doc/BRIEF.md
# Buffered I2C Burst Master

This block is an I2C master that moves one burst of 1 to 16 bytes between a local byte buffer and a single addressed target. Software prepares a burst through a small byte-wide register window. It sets a length field, an 8-bit target byte (7-bit target address plus a direction flag) and, for writes, the buffer contents. It then issues a start command. The engine sends a start condition and the target byte, then either transmits buffer bytes or fills the buffer with received bytes. After the burst it holds the bus with SCL low until software issues a separate stop command. Status bits show progress (busy), a failed acknowledge (error), and successful completion (a fixed done code).

The bus pins are open-drain. Each of SCL and SDA has an output-enable that pulls the line low, plus an input that samples the line. Each SCL period is four quarter-phases, and each quarter-phase lasts `QDIV` system clocks. When the master releases SCL, it waits until the line really reads high, so a target that holds SCL low is simply waited for.

Engine states and transitions. From IDLE, a start command moves to START. START (four quarters: both lines released, SDA pulled low, SCL pulled low) moves to BIT. BIT shifts eight bits, then moves to ACK. ACK moves back to BIT for the next byte. ACK moves to HOLD on an error or when the last byte is done. HOLD keeps SCL and SDA low. A stop command moves HOLD to STOP. STOP releases SCL, then SDA, then returns to IDLE.

Top module: `i2cb_master`

## Requirements
- R1: Offset 0x00 (length) keeps only its low 4 bits and reads back with bits 7:4 zero. A burst moves length+1 data bytes, so 1 to 16.
- R2: Offsets 0x04 to 0x13 are a 16-byte buffer, where offset 0x04+i is byte i. Write bursts send byte 0 first. Read bursts store the i-th received byte into byte i.
- R3: Offset 0x03 holds the target byte: bits 7:1 are the target address and bit 0 is the direction (1 = read, 0 = write). It is the first byte on the wire, sent most significant bit first.
- R4: A write to offset 0x01 (control) with bits 0 and 2 set starts a burst from IDLE. A write with bit 0 set and bit 2 clear is the stop command: it clears status bit 2 and, in HOLD, ends the bus transaction. A write with bit 0 clear does nothing, and control writes made while busy are ignored.
- R5: If the target does not acknowledge the target byte or a written data byte, status bit 2 (error) is set, no further byte is sent, and busy falls.
- R6: When every byte of a burst is acknowledged (or, for reads, received), the status register becomes exactly 0x08.
- R7: A write to offset 0x02 clears status bit 2 and leaves the other status bits unchanged.
- R8: After reset, the length, status, target byte and all 16 buffer bytes read zero. Reads of offsets 0x01 and 0x14 to 0x1F return zero.
- R9: Status bit 0 (busy) is high from the cycle after an accepted start command until the last byte ends or an error occurs.
- R10: In a read burst, the master pulls SDA low (ACK) after every received byte except the last, and leaves it released (NACK) after the last byte.
- R11: After a burst ends, SCL stays pulled low until the stop command. The stop then releases SCL, then SDA while SCL is high, leaving both lines released.
- R12: During byte transfer, SDA changes only while SCL is pulled low. The SCL period is 4*QDIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Some properties are checked on every cycle:
- SDA stays stable while SCL is released during bit and acknowledge phases.
- Busy only rises after a start command.
- Whenever busy falls, the status holds either the done code or the error bit.
- A reset-register write while idle clears only the error bit.
- SCL stays low throughout HOLD.

Other behaviour can only be shown by the bench's scenarios, which use a target model on the open-drain lines:
- the bytes that appear on the wire, and the order and length of the buffer traffic;
- ACK/NACK placement on reads, abandonment at a refused byte, and the SCL period;
- commands being ignored while busy, including stray control writes.

// File: rtl/i2cb_pkg.sv
`timescale 1ns/1ps
package i2cb_pkg;
    localparam int ADDR_W    = 5;
    localparam int BUF_DEPTH = 16;
    localparam int IDX_W     = $clog2(BUF_DEPTH);

    localparam logic [ADDR_W-1:0] OFS_LEN  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h01;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_TGT  = 5'h03;
    localparam logic [ADDR_W-1:0] OFS_BUF  = 5'h04;

    localparam int CTL_GO    = 0;
    localparam int CTL_START = 2;
    localparam int STA_ERR   = 2;
    localparam logic [7:0] DONE_CODE = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_HOLD,
        ST_STOP
    } eng_state_t;
endpackage

// File: rtl/i2cb_tick.sv
`timescale 1ns/1ps
module i2cb_tick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cb_buf.sv
`timescale 1ns/1ps
module i2cb_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [IW-1:0] bus_idx,
    input  logic [W-1:0]  bus_wdata,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_widx,
    input  logic [W-1:0]  eng_wdata,
    input  logic [IW-1:0] eng_ridx,
    output logic [W-1:0]  eng_rdata,
    output logic [W-1:0]  bus_rdata
);
    logic [DEPTH-1:0][W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (eng_we && eng_widx == IW'(g))
                q <= eng_wdata;
            else if (bus_we && bus_idx == IW'(g))
                q <= bus_wdata;
        end
        assign flat[g] = q;
    end

    assign eng_rdata = flat[eng_ridx];
    assign bus_rdata = flat[bus_idx];
endmodule

// File: rtl/i2cb_engine.sv
`timescale 1ns/1ps
module i2cb_engine
    import i2cb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic [7:0]       tgt_byte,
    input  logic [IDX_W-1:0] len,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_low,
    output logic             sda_low,
    output logic             busy,
    output logic             run,
    output eng_state_t       state_o,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_data,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_widx,
    output logic [7:0]       buf_wdata,
    output logic             evt_done,
    output logic             evt_err
);
    eng_state_t       state, n_state;
    logic [1:0]       ph, n_ph;
    logic [2:0]       bitn, n_bitn;
    logic [IDX_W-1:0] idx, n_idx, len_q, n_len;
    logic             dir_rd, n_rd, is_addr, n_isaddr, ack_bad, n_ackbad;
    logic [7:0]       shreg, n_sh;
    logic             stall, tx_now, n_tx, adv;

    assign stall  = (ph == 2'd1) && !scl_in;
    assign tx_now = is_addr | ~dir_rd;
    assign n_tx   = n_isaddr | ~n_rd;
    assign rd_idx = is_addr ? '0 : idx + 1'b1;

    // next-state and datapath
    always_comb begin
        n_state = state;   n_ph = ph;      n_bitn = bitn;   n_idx = idx;
        n_len = len_q;     n_rd = dir_rd;  n_isaddr = is_addr;
        n_sh = shreg;      n_ackbad = ack_bad;
        buf_we = 1'b0;     evt_done = 1'b0; evt_err = 1'b0;
        unique case (state)
            ST_IDLE: if (cmd_start) begin
                n_state = ST_START; n_ph = 2'd0; n_sh = tgt_byte;
                n_rd = tgt_byte[0]; n_len = len; n_isaddr = 1'b1;
                n_bitn = 3'd7; n_idx = '0;
            end
            ST_HOLD: if (cmd_stop) begin
                n_state = ST_STOP; n_ph = 2'd0;
            end
            ST_START: if (tick) begin
                n_ph = ph + 1'b1;
                if (ph == 2'd3) n_state = ST_BIT;
            end
            ST_BIT: if (tick && !stall) begin
                n_ph = ph + 1'b1;
                if (ph == 2'd1) n_sh = {shreg[6:0], sda_in};
                if (ph == 2'd3) begin
                    if (bitn == 3'd0) n_state = ST_ACK;
                    else              n_bitn  = bitn - 1'b1;
                end
            end
            ST_ACK: if (tick && !stall) begin
                n_ph = ph + 1'b1;
                if (ph == 2'd1) n_ackbad = sda_in;
                if (ph == 2'd3) begin
                    if (tx_now && ack_bad) begin
                        n_state = ST_HOLD; evt_err = 1'b1;
                    end else if (is_addr) begin
                        n_isaddr = 1'b0; n_idx = '0; n_sh = rd_data;
                        n_bitn = 3'd7; n_state = ST_BIT;
                    end else begin
                        buf_we = dir_rd;
                        if (idx == len_q) begin
                            n_state = ST_HOLD; evt_done = 1'b1;
                        end else begin
                            n_idx = idx + 1'b1; n_sh = rd_data;
                            n_bitn = 3'd7; n_state = ST_BIT;
                        end
                    end
                end
            end
            ST_STOP: if (tick) begin
                n_ph = ph + 1'b1;
                if (ph == 2'd3) n_state = ST_IDLE;
            end
            default: n_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE; ph <= '0; bitn <= '0; idx <= '0; len_q <= '0;
            dir_rd <= 1'b0; is_addr <= 1'b0; shreg <= '0; ack_bad <= 1'b0;
        end else begin
            state <= n_state; ph <= n_ph; bitn <= n_bitn; idx <= n_idx;
            len_q <= n_len; dir_rd <= n_rd; is_addr <= n_isaddr;
            shreg <= n_sh; ack_bad <= n_ackbad;
        end
    end

    // pin outputs, updated only when a new quarter phase is entered
    assign adv = (n_state != state) || (n_ph != ph);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_low <= 1'b0; sda_low <= 1'b0;
        end else if (adv) begin
            unique case (n_state)
                ST_IDLE: begin scl_low <= 1'b0; sda_low <= 1'b0; end
                ST_START: begin
                    scl_low <= (n_ph == 2'd3);
                    sda_low <= (n_ph != 2'd0);
                end
                ST_BIT: begin
                    scl_low <= (n_ph == 2'd0) || (n_ph == 2'd3);
                    if (n_ph == 2'd0) sda_low <= n_tx & ~n_sh[7];
                end
                ST_ACK: begin
                    scl_low <= (n_ph == 2'd0) || (n_ph == 2'd3);
                    if (n_ph == 2'd0) sda_low <= ~n_tx && (n_idx != n_len);
                end
                ST_HOLD: begin scl_low <= 1'b1; sda_low <= 1'b1; end
                ST_STOP: begin
                    scl_low <= (n_ph == 2'd0);
                    sda_low <= (n_ph == 2'd0) || (n_ph == 2'd1);
                end
                default: begin scl_low <= 1'b0; sda_low <= 1'b0; end
            endcase
        end
    end

    assign busy      = (state == ST_START) || (state == ST_BIT) || (state == ST_ACK);
    assign run       = busy || (state == ST_STOP);
    assign state_o   = state;
    assign buf_widx  = idx;
    assign buf_wdata = shreg;
endmodule

// File: rtl/i2cb_master.sv
`timescale 1ns/1ps
module i2cb_master
    import i2cb_pkg::*;
#(
    parameter int QDIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    logic [IDX_W-1:0] len_q, rd_idx, buf_widx, bus_idx;
    logic [7:0]       tgt_q, status_q, eng_rdata, bus_rdata, buf_wdata;
    logic             eng_busy, run, tick, buf_we, evt_done, evt_err;
    logic             in_buf, ctrl_go, cmd_start, cmd_stop, stat_wr;
    eng_state_t       eng_state;

    assign in_buf    = (reg_addr >= OFS_BUF) && (reg_addr < OFS_BUF + ADDR_W'(BUF_DEPTH));
    assign bus_idx   = IDX_W'(reg_addr - OFS_BUF);
    assign ctrl_go   = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTL_GO] && !eng_busy;
    assign cmd_start = ctrl_go && reg_wdata[CTL_START];
    assign cmd_stop  = ctrl_go && !reg_wdata[CTL_START];
    assign stat_wr   = reg_wr && (reg_addr == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0; tgt_q <= '0; status_q <= '0;
        end else begin
            if (reg_wr && reg_addr == OFS_LEN) len_q <= reg_wdata[IDX_W-1:0];
            if (reg_wr && reg_addr == OFS_TGT) tgt_q <= reg_wdata;
            if (evt_done)
                status_q <= DONE_CODE;
            else if (evt_err)
                status_q[STA_ERR] <= 1'b1;
            else if (stat_wr || cmd_stop)
                status_q[STA_ERR] <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_buf)                      reg_rdata = bus_rdata;
        else if (reg_addr == OFS_LEN)    reg_rdata = {{(8-IDX_W){1'b0}}, len_q};
        else if (reg_addr == OFS_STAT)   reg_rdata = status_q | {7'd0, eng_busy};
        else if (reg_addr == OFS_TGT)    reg_rdata = tgt_q;
    end

    i2cb_tick #(.QDIV(QDIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    i2cb_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .bus_we(reg_wr && in_buf), .bus_idx(bus_idx), .bus_wdata(reg_wdata),
        .eng_we(buf_we), .eng_widx(buf_widx), .eng_wdata(buf_wdata),
        .eng_ridx(rd_idx), .eng_rdata(eng_rdata), .bus_rdata(bus_rdata)
    );

    i2cb_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .tgt_byte(tgt_q), .len(len_q),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_low(scl_oe), .sda_low(sda_oe),
        .busy(eng_busy), .run(run), .state_o(eng_state),
        .rd_idx(rd_idx), .rd_data(eng_rdata),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
        .evt_done(evt_done), .evt_err(evt_err)
    );
endmodule

// File: rtl/i2cb_checker.sv
`timescale 1ns/1ps
module i2cb_checker
    import i2cb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              busy,
    input logic [7:0]        status,
    input logic              scl_oe,
    input logic              sda_oe,
    input eng_state_t        state
);
    // R12: data line steady while the clock line is released inside a byte
    p_sda_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BIT || state == ST_ACK) && !scl_oe && !$past(scl_oe)
         && ($past(state) == ST_BIT || $past(state) == ST_ACK))
        |-> $stable(sda_oe));

    // R4: a burst only begins after a start command
    p_start_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == OFS_CTRL
                              && reg_wdata[CTL_GO] && reg_wdata[CTL_START]));

    // R6 and R5: a finished burst leaves the done code or the error bit
    p_end_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (status == DONE_CODE || status[STA_ERR]));

    // R7: reset register clears only the error bit
    p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_STAT && !busy)
        |=> (!status[STA_ERR] && status[3] == $past(status[3])));

    // R11: clock line held low while waiting for stop
    p_hold_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> scl_oe);
endmodule

bind i2cb_master i2cb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(eng_busy), .status(status_q),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .state(eng_state)
);

// File: tb/i2cb_master_test.sv
`timescale 1ns/1ps
module i2cb_master_test;
    localparam int Q = 4;
    localparam logic [6:0] TGT_ID = 7'h50;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic scl_oe, sda_oe, tgt_sda_low = 1'b0;
    logic scl_line, sda_line;
    int total = 0, bad = 0;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | tgt_sda_low);

    always #2.5 clk = ~clk;

    i2cb_master #(.QDIV(Q)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // ---------------- target model ----------------
    int tgt_len = 1, tgt_nack_at = -1, tgt_wr_n = 0, tgt_starts = 0;
    logic [7:0] tgt_log [16];
    logic       tgt_mack [16];
    logic [7:0] tgt_addr_seen = '0, salt = 8'h3c, tb_b, tb_d;

    function automatic logic [7:0] tpat(input int i);
        return salt ^ (8'(i) * 8'h1d + 8'h03);
    endfunction

    task automatic recv_byte(output logic [7:0] v);
        for (int j = 0; j < 8; j++) begin
            @(posedge scl_line);
            v = {v[6:0], sda_line};
        end
    endtask

    initial begin
        forever begin
            @(negedge sda_line);
            if (scl_line !== 1'b1) continue;
            tgt_starts++;
            recv_byte(tb_b);
            tgt_addr_seen = tb_b;
            @(negedge scl_line);
            tgt_sda_low = (tb_b[7:1] == TGT_ID) && (tgt_nack_at != 0);
            @(negedge scl_line);
            if (tgt_sda_low == 1'b0) continue;
            tgt_sda_low = 1'b0;
            if (!tb_b[0]) begin
                for (int k = 1; k <= tgt_len; k++) begin
                    recv_byte(tb_d);
                    tgt_log[k-1] = tb_d;
                    tgt_wr_n = k;
                    @(negedge scl_line);
                    tgt_sda_low = (tgt_nack_at != k);
                    @(negedge scl_line);
                    tgt_sda_low = 1'b0;
                    if (tgt_nack_at == k) break;
                end
            end else begin
                for (int k = 0; k < tgt_len; k++) begin
                    tb_d = tpat(k);
                    for (int j = 7; j >= 0; j--) begin
                        tgt_sda_low = ~tb_d[j];
                        @(posedge scl_line);
                        @(negedge scl_line);
                    end
                    tgt_sda_low = 1'b0;
                    @(posedge scl_line);
                    tgt_mack[k] = sda_line;
                    @(negedge scl_line);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(5'h02, s);
            if (!s[0]) break;
        end
    endtask

    task automatic burst(input logic [7:0] tb_addr, input logic [3:0] cnt);
        wr(5'h00, {4'h0, cnt});
        wr(5'h03, tb_addr);
        tgt_len = int'(cnt) + 1;
        tgt_wr_n = 0;
        wr(5'h01, 8'h05);
        wait_idle();
    endtask

    task automatic stop_bus();
        wr(5'h01, 8'h01);
        repeat (8 * Q) @(negedge clk);
    endtask

    logic [7:0] v, exp_st;
    logic [7:0] wdat [16];
    realtime t1, t2;

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset values
        for (int a = 0; a < 20; a++) begin
            rd(5'(a), v);
            chk("R8 reset value", v, 8'h00);
        end
        chk("R8 lines released", {scl_oe, sda_oe}, 2'b00);

        // R1: length keeps low four bits
        wr(5'h00, 8'hF3);
        rd(5'h00, v);
        chk("R1 length mask", v, 8'h03);

        // R2: buffer read-back, R8 unmapped reads
        for (int i = 0; i < 16; i++) wr(5'(4 + i), 8'(8'h11 * i + 8'h07));
        for (int i = 0; i < 16; i++) begin
            rd(5'(4 + i), v);
            chk("R2 buffer readback", v, 8'(8'h11 * i + 8'h07));
        end
        for (int a = 20; a < 32; a++) begin
            rd(5'(a), v);
            chk("R8 unmapped read", v, 8'h00);
        end
        rd(5'h01, v);
        chk("R8 control reads zero", v, 8'h00);

        // R4: control write with bit 0 clear does nothing
        wr(5'h01, 8'h04);
        repeat (20 * Q) @(negedge clk);
        chk("R4 go clear ignored starts", tgt_starts, 0);
        chk("R4 go clear ignored scl", scl_oe, 1'b0);
        rd(5'h02, v);
        chk("R4 go clear status", v, 8'h00);

        // R3 R2 R6 R9 R12: directed write burst of 4 bytes
        wr(5'h00, 8'h03);
        wr(5'h03, {TGT_ID, 1'b0});
        tgt_len = 4; tgt_wr_n = 0;
        wr(5'h01, 8'h05);
        rd(5'h02, v);
        chk("R9 busy after start", v[0], 1'b1);
        @(negedge scl_line); t1 = $realtime;
        @(negedge scl_line); t2 = $realtime;
        chk("R12 scl period ns", 32'(int'(t2 - t1)), 32'(4 * Q * 5));
        wait_idle();
        rd(5'h02, v);
        chk("R6 done code", v, 8'h08);
        chk("R3 target byte on wire", tgt_addr_seen, {TGT_ID, 1'b0});
        chk("R1 bytes moved", tgt_wr_n, 4);
        for (int i = 0; i < 4; i++)
            chk("R2 sent byte order", tgt_log[i], 8'(8'h11 * i + 8'h07));
        repeat (40) @(negedge clk);
        chk("R11 scl held low", scl_oe, 1'b1);
        stop_bus();
        chk("R11 lines released after stop", {scl_oe, sda_oe}, 2'b00);

        // R1 R2 R10: read burst of 16 bytes
        salt = 8'h5a;
        burst({TGT_ID, 1'b1}, 4'hF);
        rd(5'h02, v);
        chk("R6 read done", v, 8'h08);
        for (int i = 0; i < 16; i++) begin
            rd(5'(4 + i), v);
            chk("R2 read into buffer", v, tpat(i));
        end
        for (int i = 0; i < 15; i++) chk("R10 master ack", tgt_mack[i], 1'b0);
        chk("R10 master nack last", tgt_mack[15], 1'b1);
        stop_bus();

        // R5 R7: target byte not acknowledged
        tgt_starts = 0;
        burst({7'h42, 1'b0}, 4'h2);
        rd(5'h02, v);
        chk("R5 address nack status", v, 8'h0C);
        chk("R5 no data after nack", tgt_wr_n, 0);
        wr(5'h02, 8'hFF);
        rd(5'h02, v);
        chk("R7 reset clears error only", v, 8'h08);
        stop_bus();

        // R5 R4: data byte 2 refused, stop clears error
        tgt_nack_at = 2;
        burst({TGT_ID, 1'b0}, 4'h5);
        rd(5'h02, v);
        chk("R5 data nack status", v, 8'h0C);
        chk("R5 abandoned at byte", tgt_wr_n, 2);
        stop_bus();
        rd(5'h02, v);
        chk("R4 stop clears error", v, 8'h08);
        tgt_nack_at = -1;

        // R4 R9: control writes while busy are ignored
        wr(5'h00, 8'h02);
        wr(5'h03, {TGT_ID, 1'b0});
        tgt_len = 3; tgt_wr_n = 0;
        wr(5'h01, 8'h05);
        repeat (10) @(negedge clk);
        wr(5'h01, 8'h01);
        wr(5'h01, 8'h05);
        wait_idle();
        chk("R4 busy writes ignored count", tgt_wr_n, 3);
        repeat (20) @(negedge clk);
        chk("R4 stop while busy ignored", scl_oe, 1'b1);
        stop_bus();

        // random bursts
        for (int n = 0; n < 6; n++) begin
            logic dir;
            logic [3:0] cnt;
            dir = 1'($urandom);
            cnt = 4'($urandom);
            salt = 8'($urandom);
            for (int i = 0; i < 16; i++) begin
                wdat[i] = 8'($urandom);
                wr(5'(4 + i), wdat[i]);
            end
            burst({TGT_ID, dir}, cnt);
            rd(5'h02, v);
            chk("R6 random done", v, 8'h08);
            if (dir) begin
                for (int i = 0; i < 16; i++) begin
                    rd(5'(4 + i), v);
                    chk("R2 random read buffer", v, (i <= int'(cnt)) ? tpat(i) : wdat[i]);
                end
                chk("R10 random last nack", tgt_mack[cnt], 1'b1);
            end else begin
                chk("R1 random length", tgt_wr_n, int'(cnt) + 1);
                for (int i = 0; i <= int'(cnt); i++)
                    chk("R2 random sent", tgt_log[i], wdat[i]);
            end
            stop_bus();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #750000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule